// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Used-Bit Replacement

This block holds up to 64 address translations and searches all of them in parallel. Each slot records a virtual page, a page-size code, a partition number, a context number, a real-translation flag, a lock flag and a 64-bit translation data word. A lookup is purely combinational. It reports a hit, the index of the matching slot and the physical address. The physical address takes the slot's physical page bits above the page size and the request's own address bits below it.

Maintenance commands arrive on a single 3-bit command input and take effect at the next rising clock edge. The commands are insert, remove one page, remove a context, remove a partition's unlocked slots, and clear everything. Replacement uses one used bit per slot. When every used bit would be set, all unlocked slots lose theirs, so locked slots are favoured to stay. A diagnostic port returns the tag word and the data word of any slot.

The lookup key (address, partition, context, real flag) is shared by lookups, inserts and page removal. At most one slot is expected to match a key. When slots of different sizes overlap, the lowest index wins.

Top module: `tlb_fa`

## Requirements
- R1: After reset every slot is invalid and every used bit is clear. A lookup then misses. On a miss, `hit`, `hit_idx` and `pa` are all zero.
- R2: With `lk_en` high, `hit` is 1 when a valid slot has equal partition, context and real flag, and its page equals the key address above the slot's size. Size code 0, 1, 2 and 3 ignores address bits below bit 13, 16, 22 and 28 respectively. `hit_idx` is the lowest such slot.
- R3: On a hit, `pa` equals the slot's data word above the size boundary, merged with `key_va` below it, truncated to PA_W bits.
- R4: Command 1 (insert) with `ins_at_idx` high writes slot `ins_idx`. The slot stores the key fields, `ins_size`, `ins_lock` and `ins_data`.
- R5: Command 1 with `ins_at_idx` low writes the lowest slot that is invalid or has a clear used bit. If no such slot exists, it writes slot ENTRIES-1.
- R6: An inserted slot becomes valid and used. In the same edge, any other valid slot with the same page, size, partition, context and real flag is invalidated.
- R7: If an insert, or a lookup that sets a used bit, leaves every used bit set, the used bits of all unlocked slots are cleared. The slot just written or hit keeps its used bit.
- R8: With command 0 and `lk_en` high, a hit on a slot whose used bit is clear sets that bit at the next edge.
- R9: Command 2 invalidates every slot that a lookup with the same key would match.
- R10: Command 3 invalidates every slot whose partition and context equal the key, locked or not.
- R11: Command 4 invalidates only the unlocked slots whose partition equals `key_part`.
- R12: Command 5 invalidates every slot and clears every used bit.
- R13: `rd_tag` for slot `rd_idx` is built as follows:
  - bits 12:0 hold the context;
  - bits 55:13 hold the stored address bits 55:13;
  - bits 59:56 hold the complement of the size code widened to four bits;
  - bit 60 holds the real flag;
  - bits 63:61 hold the partition.
  `rd_data` returns the stored data word. Removal commands leave both words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | 0 none, 1 insert, 2 remove page, 3 remove context, 4 remove partition, 5 clear all |
| key_va | input | 64 | Virtual address for lookup, insert and page removal |
| key_part | input | 3 | Partition of the key |
| key_ctx | input | 13 | Context of the key |
| key_real | input | 1 | Real-translation flag of the key |
| lk_en | input | 1 | Lookup enable |
| ins_at_idx | input | 1 | Insert at `ins_idx` instead of the replacement choice |
| ins_idx | input | IDX_W | Explicit insert slot |
| ins_size | input | 2 | Page-size code for insert |
| ins_lock | input | 1 | Lock flag for insert |
| ins_data | input | 64 | Translation data word for insert |
| hit | output | 1 | Lookup hit |
| hit_idx | output | IDX_W | Matching slot index |
| pa | output | PA_W | Translated physical address |
| rd_idx | input | IDX_W | Diagnostic slot select |
| rd_tag | output | 64 | Diagnostic tag word |
| rd_data | output | 64 | Diagnostic data word |

## Verification
The hardest state to reach from the ports is the one where every slot is valid, used and locked. In that state the replacement choice falls back to the last slot, and the used-bit clearing rule leaves the bits standing. The stimulus reaches it by first clearing the buffer and then inserting exactly ENTRIES locked translations. A further insert must then land in the last slot, which is confirmed with a lookup on its new key. The clearing rule is also driven by filling the buffer with unlocked entries. Lookups then touch slots, and later inserts must choose slots in the order the used bits dictate.

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int ENTRIES = 64,
  parameter int PA_W    = 40,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd,
  input  logic [63:0]      key_va,
  input  logic [2:0]       key_part,
  input  logic [12:0]      key_ctx,
  input  logic             key_real,
  input  logic             lk_en,
  input  logic             ins_at_idx,
  input  logic [IDX_W-1:0] ins_idx,
  input  logic [1:0]       ins_size,
  input  logic             ins_lock,
  input  logic [63:0]      ins_data,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [PA_W-1:0]  pa,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [63:0]      rd_tag,
  output logic [63:0]      rd_data
);
  localparam logic [2:0] OP_INS = 3'd1, OP_DPAGE = 3'd2, OP_DCTX = 3'd3,
                         OP_DPART = 3'd4, OP_INVAL = 3'd5;

  function automatic logic [63:0] low_mask(input logic [1:0] s);
    case (s)
      2'd0:    low_mask = 64'h0000_0000_0000_1FFF;
      2'd1:    low_mask = 64'h0000_0000_0000_FFFF;
      2'd2:    low_mask = 64'h0000_0000_003F_FFFF;
      default: low_mask = 64'h0000_0000_0FFF_FFFF;
    endcase
  endfunction

  logic [ENTRIES-1:0] valid_q, used_q, lock_q, real_q;
  logic [50:0]        vpn_q  [ENTRIES];
  logic [1:0]         size_q [ENTRIES];
  logic [2:0]         part_q [ENTRIES];
  logic [12:0]        ctx_q  [ENTRIES];
  logic [63:0]        data_q [ENTRIES];

  logic [ENTRIES-1:0] key_match, conf, ctx_sel, part_sel;
  logic [ENTRIES-1:0] v_n, u_n, l_n;
  logic               any;
  logic [IDX_W-1:0]   hidx, victim, tgt, keep;
  logic               rule;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      key_match[i] = valid_q[i] &&
                     ((({vpn_q[i], 13'd0} ^ key_va) & ~low_mask(size_q[i])) == 64'd0) &&
                     part_q[i] == key_part && ctx_q[i] == key_ctx && real_q[i] == key_real;
      conf[i]      = valid_q[i] && size_q[i] == ins_size &&
                     ((({vpn_q[i], 13'd0} ^ key_va) & ~low_mask(ins_size)) == 64'd0) &&
                     part_q[i] == key_part && ctx_q[i] == key_ctx && real_q[i] == key_real;
      ctx_sel[i]   = part_q[i] == key_part && ctx_q[i] == key_ctx;
      part_sel[i]  = part_q[i] == key_part && !lock_q[i];
    end
  end

  always_comb begin
    any    = 1'b0;
    hidx   = '0;
    victim = IDX_W'(ENTRIES - 1);
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (key_match[i]) begin
        any  = 1'b1;
        hidx = IDX_W'(i);
      end
      if (!valid_q[i] || !used_q[i]) victim = IDX_W'(i);
    end
  end

  assign tgt     = ins_at_idx ? ins_idx : victim;
  assign hit     = lk_en & any;
  assign hit_idx = hit ? hidx : '0;
  assign pa      = hit ? PA_W'((data_q[hidx] & ~low_mask(size_q[hidx])) |
                               (key_va & low_mask(size_q[hidx]))) : '0;
  assign rd_tag  = {part_q[rd_idx], real_q[rd_idx], 2'b11, ~size_q[rd_idx],
                    vpn_q[rd_idx][42:0], ctx_q[rd_idx]};
  assign rd_data = data_q[rd_idx];

  always_comb begin
    v_n  = valid_q;
    u_n  = used_q;
    l_n  = lock_q;
    keep = hidx;
    rule = 1'b0;
    case (cmd)
      OP_INS: begin
        v_n      = v_n & ~conf;
        u_n      = u_n & ~conf;
        v_n[tgt] = 1'b1;
        u_n[tgt] = 1'b1;
        l_n[tgt] = ins_lock;
        keep     = tgt;
        rule     = 1'b1;
      end
      OP_DPAGE: begin v_n = v_n & ~key_match; u_n = u_n & ~key_match; end
      OP_DCTX:  begin v_n = v_n & ~ctx_sel;   u_n = u_n & ~ctx_sel;   end
      OP_DPART: begin v_n = v_n & ~part_sel;  u_n = u_n & ~part_sel;  end
      OP_INVAL: begin v_n = '0;               u_n = '0;               end
      default: begin
        if (lk_en && any && !used_q[hidx]) begin
          u_n[hidx] = 1'b1;
          rule      = 1'b1;
        end
      end
    endcase
    if (rule && $countones(u_n) == ENTRIES) begin
      u_n       = u_n & l_n;
      u_n[keep] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      used_q  <= '0;
      lock_q  <= '0;
      real_q  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i]  <= '0;
        size_q[i] <= '0;
        part_q[i] <= '0;
        ctx_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      valid_q <= v_n;
      used_q  <= u_n;
      lock_q  <= l_n;
      if (cmd == OP_INS) begin
        vpn_q[tgt]  <= key_va[63:13];
        size_q[tgt] <= ins_size;
        part_q[tgt] <= key_part;
        ctx_q[tgt]  <= key_ctx;
        real_q[tgt] <= key_real;
        data_q[tgt] <= ins_data;
      end
    end
  end

  assert_used_implies_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (used_q & ~valid_q) == '0);

  assert_used_never_saturated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(used_q) != ENTRIES) || ($countones(~lock_q) <= 1));

  assert_insert_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == OP_INS |=> valid_q[$past(tgt)] && used_q[$past(tgt)]);

  assert_clear_all_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == OP_INVAL |=> valid_q == '0 && used_q == '0);

  assert_locked_survive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == OP_DPART |=> (valid_q & $past(valid_q & lock_q)) == $past(valid_q & lock_q));

  assert_miss_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_idx == '0 && pa == '0));
endmodule

// File: tb/tlb_fa_tb_top.sv
module tlb_fa_tb_top;
  localparam int N    = 8;
  localparam int PA_W = 40;
  localparam int IW   = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cmd = '0;
  logic [63:0] key_va = '0;
  logic [2:0] key_part = '0;
  logic [12:0] key_ctx = '0;
  logic key_real = 1'b0, lk_en = 1'b0, ins_at_idx = 1'b0, ins_lock = 1'b0;
  logic [IW-1:0] ins_idx = '0, rd_idx = '0;
  logic [1:0] ins_size = '0;
  logic [63:0] ins_data = '0;
  logic hit;
  logic [IW-1:0] hit_idx;
  logic [PA_W-1:0] pa;
  logic [63:0] rd_tag, rd_data;

  always #5 clk = ~clk;

  tlb_fa #(.ENTRIES(N), .PA_W(PA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .key_va(key_va), .key_part(key_part),
    .key_ctx(key_ctx), .key_real(key_real), .lk_en(lk_en), .ins_at_idx(ins_at_idx),
    .ins_idx(ins_idx), .ins_size(ins_size), .ins_lock(ins_lock), .ins_data(ins_data),
    .hit(hit), .hit_idx(hit_idx), .pa(pa), .rd_idx(rd_idx), .rd_tag(rd_tag),
    .rd_data(rd_data));

  bit m_v[N], m_u[N], m_lk[N], m_rl[N];
  logic [63:0] m_va[N], m_dt[N];
  logic [1:0] m_sz[N];
  logic [2:0] m_pt[N];
  logic [12:0] m_cx[N];

  int checks = 0, errors = 0;
  string cur_req = "R1";
  int cyc = 0;

  function automatic int shamt(input logic [1:0] s);
    case (s) 2'd0: return 13; 2'd1: return 16; 2'd2: return 22; default: return 28; endcase
  endfunction

  function automatic bit key_hits(input int i);
    int sh = shamt(m_sz[i]);
    return m_v[i] && ((m_va[i] >> sh) == (key_va >> sh)) && m_pt[i] == key_part &&
           m_cx[i] == key_ctx && m_rl[i] == key_real;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    int hi = -1;
    logic [63:0] mk, ep, et;
    for (int i = 0; i < N; i++) if (hi < 0 && key_hits(i)) hi = i;
    if (lk_en && hi >= 0) begin
      mk = (64'd1 << shamt(m_sz[hi])) - 64'd1;
      ep = (m_dt[hi] & ~mk) | (key_va & mk);
      chk(hit && hit_idx == IW'(hi) && pa == ep[PA_W-1:0], "lookup hit",
          {hit, 3'b0, 4'(hit_idx), 24'd0, 40'(pa)}, {1'b1, 3'b0, 4'(hi), 24'd0, ep[39:0]});
    end else begin
      chk(!hit && hit_idx == '0 && pa == '0, "lookup miss",
          {hit, 3'b0, 4'(hit_idx), 24'd0, 40'(pa)}, 128'd0);
    end
    et = 64'(m_cx[rd_idx]) | (m_va[rd_idx] & 64'h00FF_FFFF_FFFF_E000) |
         (64'(m_pt[rd_idx]) << 61) | (64'(m_rl[rd_idx]) << 60) |
         (64'({2'b11, ~m_sz[rd_idx]}) << 56);
    chk(rd_tag == et && rd_data == m_dt[rd_idx], "R13 diag read",
        {rd_tag, rd_data}, {et, m_dt[rd_idx]});
  endtask

  task automatic use_rule(input int keep);
    int cnt = 0;
    for (int i = 0; i < N; i++) cnt += int'(m_u[i]);
    if (cnt == N) begin
      for (int i = 0; i < N; i++) if (!m_lk[i]) m_u[i] = 0;
      m_u[keep] = 1;
    end
  endtask

  task automatic model_step();
    int t, hi;
    bit f;
    case (cmd)
      3'd1: begin
        if (ins_at_idx) t = int'(ins_idx);
        else begin
          t = N - 1; f = 0;
          for (int i = 0; i < N; i++) if (!f && (!m_v[i] || !m_u[i])) begin t = i; f = 1; end
        end
        for (int i = 0; i < N; i++)
          if (i != t && m_v[i] && m_sz[i] == ins_size &&
              (m_va[i] >> shamt(ins_size)) == (key_va >> shamt(ins_size)) &&
              m_pt[i] == key_part && m_cx[i] == key_ctx && m_rl[i] == key_real) begin
            m_v[i] = 0; m_u[i] = 0;
          end
        m_va[t] = key_va & ~64'h1FFF; m_sz[t] = ins_size; m_pt[t] = key_part;
        m_cx[t] = key_ctx; m_rl[t] = key_real; m_lk[t] = ins_lock; m_dt[t] = ins_data;
        m_v[t] = 1; m_u[t] = 1;
        use_rule(t);
      end
      3'd2: for (int i = 0; i < N; i++) if (key_hits(i)) begin m_v[i] = 0; m_u[i] = 0; end
      3'd3: for (int i = 0; i < N; i++)
              if (m_pt[i] == key_part && m_cx[i] == key_ctx) begin m_v[i] = 0; m_u[i] = 0; end
      3'd4: for (int i = 0; i < N; i++)
              if (m_pt[i] == key_part && !m_lk[i]) begin m_v[i] = 0; m_u[i] = 0; end
      3'd5: for (int i = 0; i < N; i++) begin m_v[i] = 0; m_u[i] = 0; end
      default: if (lk_en) begin
        hi = -1;
        for (int i = 0; i < N; i++) if (hi < 0 && key_hits(i)) hi = i;
        if (hi >= 0 && !m_u[hi]) begin m_u[hi] = 1; use_rule(hi); end
      end
    endcase
  endtask

  task automatic cycle();
    rd_idx = IW'(cyc % N);
    cyc++;
    @(negedge clk);
    compare();
    model_step();
    @(posedge clk);
    #1;
    cmd = 3'd0; lk_en = 1'b0; ins_at_idx = 1'b0;
  endtask

  task automatic set_key(input logic [63:0] va, input logic [2:0] pt, input logic [12:0] cx, input logic rl);
    key_va = va; key_part = pt; key_ctx = cx; key_real = rl;
  endtask

  task automatic ins(input logic [63:0] va, input logic [1:0] sz, input logic [2:0] pt,
                     input logic [12:0] cx, input logic rl, input logic lk, input logic [63:0] dt);
    set_key(va, pt, cx, rl); ins_size = sz; ins_lock = lk; ins_data = dt; cmd = 3'd1;
    cycle();
  endtask

  task automatic ins_at(input int ix, input logic [63:0] va, input logic [1:0] sz, input logic [2:0] pt,
                        input logic [12:0] cx, input logic rl, input logic lk, input logic [63:0] dt);
    ins_at_idx = 1'b1; ins_idx = IW'(ix);
    ins(va, sz, pt, cx, rl, lk, dt);
  endtask

  task automatic look(input logic [63:0] va, input logic [2:0] pt, input logic [12:0] cx, input logic rl);
    set_key(va, pt, cx, rl); lk_en = 1'b1;
    cycle();
  endtask

  task automatic op(input logic [2:0] c, input logic [63:0] va, input logic [2:0] pt, input logic [12:0] cx, input logic rl);
    set_key(va, pt, cx, rl); cmd = c;
    cycle();
  endtask

  task automatic expect_idx(input int ix);
    @(negedge clk);
    chk(hit && int'(hit_idx) == ix, "expected slot", 128'(hit_idx), 128'(ix));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_va[i] = '0; m_dt[i] = '0; m_sz[i] = '0; m_pt[i] = '0; m_cx[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    cur_req = "R1";
    @(negedge clk);
    chk(rd_tag == 64'h0F00_0000_0000_0000, "R1 reset tag", 128'(rd_tag), 128'h0F00_0000_0000_0000);
    look(64'h1234_5000, 3'd0, 13'd0, 1'b0);

    cur_req = "R2";
    ins(64'h0000_1234_5678_A000, 2'd0, 3'd1, 13'd5, 1'b0, 1'b0, 64'h0000_00AB_CDE0_0000);
    ins(64'h0000_0000_4446_0000, 2'd1, 3'd1, 13'd5, 1'b0, 1'b0, 64'h0000_0011_2230_0000);
    ins(64'h0000_0000_8840_0000, 2'd2, 3'd2, 13'd7, 1'b1, 1'b0, 64'h0000_0077_0000_0000);
    ins(64'h0000_0003_0000_0000, 2'd3, 3'd2, 13'd9, 1'b0, 1'b0, 64'h0000_00F0_0000_0000);
    cur_req = "R3";
    look(64'h0000_1234_5678_BABC, 3'd1, 13'd5, 1'b0);
    set_key(64'h0000_1234_5678_BABC, 3'd1, 13'd5, 1'b0); lk_en = 1'b1;
    @(negedge clk);
    chk(pa == 40'hAB_CDE0_1ABC, "R3 hand pa", 128'(pa), 128'hAB_CDE0_1ABC);
    @(posedge clk); #1 lk_en = 1'b0;
    look(64'h0000_0000_4446_F00D, 3'd1, 13'd5, 1'b0);
    look(64'h0000_0000_887F_FFF8, 3'd2, 13'd7, 1'b1);
    look(64'h0000_0003_0ABC_DEF0, 3'd2, 13'd9, 1'b0);
    cur_req = "R2";
    look(64'h0000_1234_5678_BABC, 3'd1, 13'd6, 1'b0);
    look(64'h0000_1234_5678_BABC, 3'd0, 13'd5, 1'b0);
    look(64'h0000_1234_5678_BABC, 3'd1, 13'd5, 1'b1);
    look(64'h0000_0000_8880_0000, 3'd2, 13'd7, 1'b1);

    cur_req = "R6";
    ins(64'h0000_1234_5678_A000, 2'd0, 3'd1, 13'd5, 1'b0, 1'b0, 64'h0000_0055_5540_0000);
    set_key(64'h0000_1234_5678_A010, 3'd1, 13'd5, 1'b0); lk_en = 1'b1;
    expect_idx(4);
    @(posedge clk); #1 lk_en = 1'b0;

    cur_req = "R7";
    for (int k = 0; k < 4; k++)
      ins(64'h0000_0100_0000_0000 + 64'(k) * 64'h2000, 2'd0, 3'd3, 13'd1, 1'b0, 1'b0, 64'(k) << 20);
    cur_req = "R8";
    look(64'h0000_0000_4446_0000, 3'd1, 13'd5, 1'b0);
    cur_req = "R5";
    ins(64'h0000_0200_0000_0000, 2'd0, 3'd4, 13'd2, 1'b0, 1'b0, 64'h0000_0012_3450_0000);
    ins(64'h0000_0202_0000_0000, 2'd0, 3'd4, 13'd2, 1'b0, 1'b0, 64'h0000_0012_3460_0000);
    set_key(64'h0000_0202_0000_0000, 3'd4, 13'd2, 1'b0); lk_en = 1'b1;
    expect_idx(2);
    @(posedge clk); #1 lk_en = 1'b0;

    cur_req = "R4";
    ins_at(5, 64'h0000_0300_0000_0000, 2'd1, 3'd5, 13'd3, 1'b1, 1'b1, 64'h0000_0099_0000_0000);
    set_key(64'h0000_0300_0000_1234, 3'd5, 13'd3, 1'b1); lk_en = 1'b1;
    expect_idx(5);
    @(posedge clk); #1 lk_en = 1'b0;

    cur_req = "R9";
    op(3'd2, 64'h0000_0300_0000_8000, 3'd5, 13'd4, 1'b1);
    look(64'h0000_0300_0000_1234, 3'd5, 13'd3, 1'b1);
    op(3'd2, 64'h0000_0300_0000_8000, 3'd5, 13'd3, 1'b1);
    look(64'h0000_0300_0000_1234, 3'd5, 13'd3, 1'b1);

    cur_req = "R12";
    op(3'd5, 64'd0, 3'd0, 13'd0, 1'b0);
    look(64'h0000_0202_0000_0000, 3'd4, 13'd2, 1'b0);

    cur_req = "R11";
    ins(64'h0000_0400_0000_0000, 2'd0, 3'd6, 13'd8, 1'b0, 1'b1, 64'h0000_0001_0000_0000);
    ins(64'h0000_0402_0000_0000, 2'd0, 3'd6, 13'd8, 1'b0, 1'b0, 64'h0000_0002_0000_0000);
    ins(64'h0000_0404_0000_0000, 2'd0, 3'd6, 13'd9, 1'b0, 1'b0, 64'h0000_0003_0000_0000);
    op(3'd4, 64'd0, 3'd6, 13'd0, 1'b0);
    look(64'h0000_0400_0000_0000, 3'd6, 13'd8, 1'b0);
    look(64'h0000_0402_0000_0000, 3'd6, 13'd8, 1'b0);
    cur_req = "R10";
    op(3'd3, 64'd0, 3'd6, 13'd8, 1'b0);
    look(64'h0000_0400_0000_0000, 3'd6, 13'd8, 1'b0);

    cur_req = "R5";
    op(3'd5, 64'd0, 3'd0, 13'd0, 1'b0);
    for (int k = 0; k < N; k++)
      ins(64'h0000_0500_0000_0000 + 64'(k) * 64'h2000, 2'd0, 3'd1, 13'd1, 1'b0, 1'b1, 64'(k + 1) << 24);
    ins(64'h0000_0600_0000_0000, 2'd0, 3'd1, 13'd1, 1'b0, 1'b0, 64'h0000_0077_7700_0000);
    set_key(64'h0000_0600_0000_0040, 3'd1, 13'd1, 1'b0); lk_en = 1'b1;
    expect_idx(N - 1);
    @(posedge clk); #1 lk_en = 1'b0;
    cur_req = "R7";
    ins(64'h0000_0700_0000_0000, 2'd0, 3'd1, 13'd1, 1'b0, 1'b0, 64'h0000_0066_6600_0000);

    cur_req = "R2";
    op(3'd5, 64'd0, 3'd0, 13'd0, 1'b0);
    for (int k = 0; k < 400; k++) begin
      int r = $urandom_range(0, 9);
      logic [63:0] va = {40'd0, 4'($urandom_range(0, 3)), 20'($urandom)};
      logic [2:0] pt = 3'($urandom_range(0, 1));
      logic [12:0] cx = 13'($urandom_range(0, 1));
      logic rl = 1'($urandom_range(0, 1));
      if (r < 3) begin
        ins_at_idx = 1'($urandom_range(0, 3) == 0); ins_idx = IW'($urandom);
        ins(va, 2'($urandom), pt, cx, rl, 1'($urandom_range(0, 2) == 0), 64'($urandom) << 13);
      end else if (r < 7) look(va, pt, cx, rl);
      else if (r == 7) op(3'd2, va, pt, cx, rl);
      else if (r == 8) op(3'(3 + $urandom_range(0, 1)), va, pt, cx, rl);
      else if ($urandom_range(0, 9) == 0) op(3'd5, va, pt, cx, rl);
      else look(va, pt, cx, rl);
    end

    finish_run();
  end
endmodule